// File: doc/BRIEF.md
# Task Queue With Completion Barrier

This block is a shared queue of fixed-width task descriptors that a group of requesters both fills and drains. Any requester may add a descriptor or ask for one; a request for work on an empty queue is not refused but held, and the requester is parked until a descriptor arrives. Parked requesters are woken in the order in which they were parked. Requesters that are already running tasks may keep adding work, so the amount of work in an interval is open-ended.

The queue also tracks how many of the participating requesters are parked. When the queue is empty and every participant is parked, no more work can ever appear in this interval. The queue then enters a completed state and answers every parked request at once with a barrier notification instead of a descriptor. Once each participant has acknowledged the notification, the queue reopens, empty, for the next interval. The number of participants (the lowest-numbered ports) and the occupancy limit are set by configuration inputs.

Top module: `tq_barrier_queue`

## Requirements
- R1: After reset no response strobe is high and `q_state` reads EMPTY, encoded 0.
- R2: Descriptors leave in the order they were accepted. An accepted add or a served take is answered by a one-cycle strobe on that port in the cycle after the request is granted. While descriptors are held below the limit, `q_state` reads AVAILABLE, encoded 1.
- R3: When occupancy equals the smaller of `cfg_limit` and the storage depth, `q_state` reads FULL, encoded 2. An add request is then answered with `enq_full` = 1 and stores nothing.
- R4: A take request on an empty queue gets no response while not every participant is parked, and `q_state` stays EMPTY.
- R5: When a descriptor is added while requesters are parked, the parked requesters receive descriptors one at a time, in the order in which they parked.
- R6: When the last participant parks on an empty queue, `q_state` reads COMPLETED (encoded 3). In one cycle every participant then receives a take response with `deq_bar` = 1.
- R7: While in COMPLETED no add or take request is served. After every participant has pulsed `bar_ack`, `q_state` returns to EMPTY and service resumes.
- R8: At most one descriptor operation (add, take or wake) completes per cycle. Simultaneous requests are granted round-robin, starting from the port after the most recently granted one.
- R9: Ports numbered `cfg_part` or higher are never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_part | input | $clog2(N+1) | Number of participating ports (ports 0 to cfg_part-1) |
| cfg_limit | input | $clog2(DEPTH+1) | Occupancy limit, clamped to DEPTH |
| enq_req | input | N | Per-port add request, held until its response |
| enq_data | input | N*W | Per-port descriptor to add, port p in bits p*W +: W |
| enq_rsp | output | N | Per-port one-cycle add response |
| enq_full | output | N | With enq_rsp: 1 means rejected because the queue was full |
| deq_req | input | N | Per-port take request, held until its response |
| deq_rsp | output | N | Per-port one-cycle take response |
| deq_bar | output | N | With deq_rsp: 1 means barrier notification, not a descriptor |
| deq_data | output | N*W | Per-port returned descriptor, port p in bits p*W +: W |
| bar_ack | input | N | Per-port one-cycle barrier acknowledge |
| q_state | output | 2 | Queue state: 0 EMPTY, 1 AVAILABLE, 2 FULL, 3 COMPLETED |

## Verification
An add and a wake of a parked requester can be due in the same cycle, as can several add requests from different ports. The bench parks two requesters and then feeds descriptors from a third port. It also raises three add requests on one edge and, later, two more after the grant pointer has moved. The scoreboard judges the result by the order in which descriptors reach the takers, and the monitor counts the completions that land in any one cycle. Arrival of the barrier while another port is still waiting to add is provoked as well, and judged by the add staying unanswered until the last acknowledge.

// File: rtl/tq_pkg.sv
// Shared types for the task queue: externally visible queue state and the
// internal barrier sequencing mode.
package tq_pkg;
    typedef enum logic [1:0] {
        QS_EMPTY = 2'd0,
        QS_AVAIL = 2'd1,
        QS_FULL  = 2'd2,
        QS_DONE  = 2'd3
    } qstate_e;

    typedef enum logic [1:0] {
        MD_RUN     = 2'd0,
        MD_RELEASE = 2'd1,
        MD_ACKWAIT = 2'd2
    } mode_e;
endpackage

// File: rtl/tq_ring.sv
// Circular descriptor store with occupancy count.
// Assumes the caller never pushes when full nor pops when empty.
module tq_ring #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // storage write, no reset needed for data
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // pointer and occupancy upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // oldest descriptor
    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/tq_waitlist.sv
// Ordered list of parked requester ids plus a membership mask.
// Assumes each id is pushed at most once before it is popped or cleared.
module tq_waitlist #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int NCW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IW-1:0]  push_id,
    input  logic           pop,
    input  logic           clear,
    output logic [IW-1:0]  head_id,
    output logic [N-1:0]   mask,
    output logic [NCW-1:0] cnt
);
    logic [IW-1:0] ids [N];
    logic [IW-1:0] hd;
    logic [IW-1:0] tl;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    // id storage
    always_ff @(posedge clk) begin
        if (push) ids[tl] <= push_id;
    end

    // order pointers, count and membership
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hd   <= '0;
            tl   <= '0;
            cnt  <= '0;
            mask <= '0;
        end else begin
            if (push) begin
                tl            <= step(tl);
                mask[push_id] <= 1'b1;
            end
            if (pop) begin
                hd            <= step(hd);
                mask[ids[hd]] <= 1'b0;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // first parked requester
    assign head_id = ids[hd];
endmodule

// File: rtl/tq_rr_arb.sv
// Round-robin picker: searches from the port after the last grant.
// The pointer moves only when the caller takes the grant.
module tq_rr_arb #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;

    // first requester at or after the pointer
    always_comb begin
        int j;
        any     = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any     = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    // advance past the granted port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (take && any) begin
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/tq_barrier_queue.sv
// Shared task queue with completion barrier.
// One descriptor operation per cycle: waking the oldest parked taker has
// priority over new requests, which are granted round-robin. When every
// participant is parked on an empty queue the block releases all of them
// with a barrier notification, then waits for each acknowledge.
// Assumes requests are held until answered, cfg inputs change only while
// idle, and cfg_part does not exceed N.
module tq_barrier_queue
    import tq_pkg::*;
#(
    parameter int N     = 4,
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int NCW  = $clog2(N + 1),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCW-1:0]   cfg_part,
    input  logic [CW-1:0]    cfg_limit,
    input  logic [N-1:0]     enq_req,
    input  logic [N*W-1:0]   enq_data,
    output logic [N-1:0]     enq_rsp,
    output logic [N-1:0]     enq_full,
    input  logic [N-1:0]     deq_req,
    output logic [N-1:0]     deq_rsp,
    output logic [N-1:0]     deq_bar,
    output logic [N*W-1:0]   deq_data,
    input  logic [N-1:0]     bar_ack,
    output logic [1:0]       q_state
);
    mode_e          mode;
    logic [N-1:0]   part_mask;
    logic [N-1:0]   busy;
    logic [N-1:0]   cand;
    logic [N-1:0]   ack_pend;
    logic [N-1:0]   enq_rsp_q, enq_full_q, deq_rsp_q, deq_bar_q;
    logic [N*W-1:0] deq_data_q;

    logic [W-1:0]   ring_head;
    logic [CW-1:0]  ring_cnt;
    logic [CW-1:0]  lim;
    logic           is_full;

    logic [IW-1:0]  wl_head;
    logic [N-1:0]   wl_mask;
    logic [NCW-1:0] wl_cnt;

    logic           arb_any;
    logic [IW-1:0]  sel;
    logic           wake, arb_take, is_enq, is_deq;
    logic           do_push, do_pop, do_block, do_complete;

    // participants are the lowest-numbered ports
    for (genvar g = 0; g < N; g++) begin : g_part
        assign part_mask[g] = (NCW'(g) < cfg_part);
    end

    // limit clamped to the physical depth
    assign lim     = (cfg_limit > CW'(DEPTH)) ? CW'(DEPTH) : cfg_limit;
    assign is_full = (ring_cnt >= lim);

    // ports eligible for a fresh grant this cycle
    assign busy = enq_rsp_q | deq_rsp_q;
    assign cand = part_mask & ~busy & ~wl_mask & (enq_req | deq_req);

    // operation selection for this cycle
    assign wake     = (mode == MD_RUN) && (wl_cnt != '0) && (ring_cnt != '0);
    assign arb_take = (mode == MD_RUN) && !wake && arb_any;
    assign is_enq   = arb_take && enq_req[sel];
    assign is_deq   = arb_take && !enq_req[sel] && deq_req[sel];
    assign do_push  = is_enq && !is_full;
    assign do_pop   = wake || (is_deq && ring_cnt != '0);
    assign do_block = is_deq && (ring_cnt == '0);
    assign do_complete = do_block &&
        (({1'b0, wl_cnt} + 1'b1) == {1'b0, cfg_part});

    tq_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_data (enq_data[int'(sel)*W +: W]),
        .pop       (do_pop),
        .head_data (ring_head),
        .count     (ring_cnt)
    );

    tq_waitlist #(.N(N)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (do_block),
        .push_id (sel),
        .pop     (wake),
        .clear   (mode == MD_RELEASE),
        .head_id (wl_head),
        .mask    (wl_mask),
        .cnt     (wl_cnt)
    );

    tq_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cand),
        .take    (arb_take),
        .any     (arb_any),
        .gnt_idx (sel)
    );

    // response registers and barrier sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MD_RUN;
            ack_pend   <= '0;
            enq_rsp_q  <= '0;
            enq_full_q <= '0;
            deq_rsp_q  <= '0;
            deq_bar_q  <= '0;
            deq_data_q <= '0;
        end else begin
            enq_rsp_q <= '0;
            deq_rsp_q <= '0;
            case (mode)
                MD_RUN: begin
                    if (wake) begin
                        deq_rsp_q[wl_head]                 <= 1'b1;
                        deq_bar_q[wl_head]                 <= 1'b0;
                        deq_data_q[int'(wl_head)*W +: W]   <= ring_head;
                    end else if (is_enq) begin
                        enq_rsp_q[sel]  <= 1'b1;
                        enq_full_q[sel] <= is_full;
                    end else if (is_deq && ring_cnt != '0) begin
                        deq_rsp_q[sel]             <= 1'b1;
                        deq_bar_q[sel]             <= 1'b0;
                        deq_data_q[int'(sel)*W +: W] <= ring_head;
                    end
                    if (do_complete) mode <= MD_RELEASE;
                end
                MD_RELEASE: begin
                    deq_rsp_q <= wl_mask;
                    deq_bar_q <= wl_mask;
                    ack_pend  <= wl_mask;
                    mode      <= MD_ACKWAIT;
                end
                default: begin
                    ack_pend <= ack_pend & ~bar_ack;
                    if ((ack_pend & ~bar_ack) == '0) mode <= MD_RUN;
                end
            endcase
        end
    end

    // visible queue state
    always_comb begin
        if (mode != MD_RUN)      q_state = QS_DONE;
        else if (is_full)        q_state = QS_FULL;
        else if (ring_cnt != '0) q_state = QS_AVAIL;
        else                     q_state = QS_EMPTY;
    end

    assign enq_rsp  = enq_rsp_q;
    assign enq_full = enq_full_q;
    assign deq_rsp  = deq_rsp_q;
    assign deq_bar  = deq_bar_q;
    assign deq_data = deq_data_q;
endmodule

// File: rtl/tq_barrier_queue_chk.sv
// Port-level protocol checker for the task queue, bound to every instance.
module tq_barrier_queue_chk #(
    parameter int N   = 4,
    parameter int NCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCW-1:0] cfg_part,
    input logic [N-1:0]   enq_rsp,
    input logic [N-1:0]   enq_full,
    input logic [N-1:0]   deq_rsp,
    input logic [N-1:0]   deq_bar,
    input logic [1:0]     q_state
);
    logic [N-1:0] pmask;

    // participant mask rebuilt from the configuration input
    always_comb begin
        for (int i = 0; i < N; i++) pmask[i] = (NCW'(i) < cfg_part);
    end

    assert_one_op_per_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(enq_rsp) + $countones(deq_rsp & ~deq_bar)) <= 1);

    assert_accept_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        |(enq_rsp & ~enq_full) |-> $past(q_state) != 2'd2);

    assert_reject_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        |(enq_rsp & enq_full) |-> $past(q_state) == 2'd2);

    assert_task_from_stock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        |(deq_rsp & ~deq_bar) |-> ($past(q_state) == 2'd1 || $past(q_state) == 2'd2));

    assert_barrier_to_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |(deq_rsp & deq_bar) |-> ($past(q_state) == 2'd3 && (deq_rsp & deq_bar) == pmask));

    assert_no_outsider_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((enq_rsp | deq_rsp) & ~pmask) == '0);

    assert_reopen_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_state) == 2'd3 && q_state != 2'd3) |-> q_state == 2'd0);
endmodule

bind tq_barrier_queue tq_barrier_queue_chk #(.N(N), .NCW(NCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_part (cfg_part),
    .enq_rsp  (enq_rsp),
    .enq_full (enq_full),
    .deq_rsp  (deq_rsp),
    .deq_bar  (deq_bar),
    .q_state  (q_state)
);

// File: tb/tq_barrier_queue_tb.sv
// Scoreboard bench: driver tasks queue the expected take responses, a
// negedge monitor pops and compares them as they appear.
module tq_barrier_queue_tb;
    localparam int N = 4, W = 16, DEPTH = 8;
    localparam int NCW = $clog2(N + 1), CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCW-1:0] cfg_part = NCW'(2);
    logic [CW-1:0]  cfg_limit = CW'(4);
    logic [N-1:0]   enq_req = '0, deq_req = '0, bar_ack = '0;
    logic [N*W-1:0] enq_data = '0;
    logic [N-1:0]   enq_rsp, enq_full, deq_rsp, deq_bar;
    logic [N*W-1:0] deq_data;
    logic [1:0]     q_state;

    int checks = 0, errors = 0;
    bit finished = 0;
    int          exp_port[$];
    logic [W-1:0] exp_data[$];
    bit          exp_bar[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    tq_barrier_queue #(.N(N), .W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_part(cfg_part), .cfg_limit(cfg_limit),
        .enq_req(enq_req), .enq_data(enq_data), .enq_rsp(enq_rsp), .enq_full(enq_full),
        .deq_req(deq_req), .deq_rsp(deq_rsp), .deq_bar(deq_bar), .deq_data(deq_data),
        .bar_ack(bar_ack), .q_state(q_state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_take(input int p, input logic [W-1:0] d, input bit b, input string tag);
        exp_port.push_back(p); exp_data.push_back(d);
        exp_bar.push_back(b);  exp_tag.push_back(tag);
    endtask

    task automatic do_enq(input int p, input logic [W-1:0] d, input bit exp_full, input string tag);
        @(posedge clk); #1;
        enq_data[p*W +: W] = d;
        enq_req[p] = 1'b1;
        do @(negedge clk); while (!enq_rsp[p]);
        chk(enq_full[p] == exp_full, tag, int'(enq_full[p]), int'(exp_full));
        @(posedge clk); #1;
        enq_req[p] = 1'b0;
    endtask

    task automatic do_deq(input int p);
        @(posedge clk); #1;
        deq_req[p] = 1'b1;
        do @(negedge clk); while (!deq_rsp[p]);
        @(posedge clk); #1;
        deq_req[p] = 1'b0;
    endtask

    // monitor: compares every take response and counts completions per cycle
    always @(negedge clk) begin
        if (rst_n) begin
            int nb;
            nb = $countones(enq_rsp);
            for (int p = 0; p < N; p++) begin
                if (deq_rsp[p]) begin
                    if (!deq_bar[p]) nb++;
                    if (exp_port.size() == 0) begin
                        chk(1'b0, "R2 unexpected take", p, -1);
                    end else begin
                        int ep; logic [W-1:0] ed; bit eb; string et;
                        ep = exp_port.pop_front(); ed = exp_data.pop_front();
                        eb = exp_bar.pop_front();  et = exp_tag.pop_front();
                        chk(ep == p && eb == deq_bar[p], et, p * 10 + int'(deq_bar[p]), ep * 10 + int'(eb));
                        if (!eb) chk(deq_data[p*W +: W] == ed, et, int'(deq_data[p*W +: W]), int'(ed));
                    end
                end
            end
            if (nb > 1) chk(1'b0, "R8 completions in one cycle", nb, 1);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit quiet;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(q_state == 2'd0, "R1 state after reset", q_state, 0);
        chk(enq_rsp == '0 && deq_rsp == '0, "R1 no response after reset", int'(enq_rsp | deq_rsp), 0);

        // R2: FIFO order, AVAILABLE state
        do_enq(0, 16'hA001, 1'b0, "R2 add");
        do_enq(0, 16'hA002, 1'b0, "R2 add");
        do_enq(0, 16'hA003, 1'b0, "R2 add");
        @(negedge clk);
        chk(q_state == 2'd1, "R2 state with tasks", q_state, 1);
        expect_take(1, 16'hA001, 0, "R2 order");
        expect_take(1, 16'hA002, 0, "R2 order");
        expect_take(1, 16'hA003, 0, "R2 order");
        do_deq(1); do_deq(1); do_deq(1);
        @(negedge clk);
        chk(q_state == 2'd0, "R2 drained to empty", q_state, 0);

        // R3: limit reached, extra add rejected and not stored
        do_enq(0, 16'hB000, 1'b0, "R3 add");
        do_enq(0, 16'hB001, 1'b0, "R3 add");
        do_enq(0, 16'hB002, 1'b0, "R3 add");
        do_enq(0, 16'hB003, 1'b0, "R3 add");
        @(negedge clk);
        chk(q_state == 2'd2, "R3 state at limit", q_state, 2);
        do_enq(1, 16'hBEEF, 1'b1, "R3 rejected add");
        @(negedge clk);
        chk(q_state == 2'd2, "R3 state after reject", q_state, 2);
        expect_take(0, 16'hB000, 0, "R3 contents");
        expect_take(0, 16'hB001, 0, "R3 contents");
        expect_take(0, 16'hB002, 0, "R3 contents");
        expect_take(0, 16'hB003, 0, "R3 contents");
        do_deq(0); do_deq(0); do_deq(0); do_deq(0);
        @(negedge clk);
        chk(q_state == 2'd0, "R3 nothing extra stored", q_state, 0);

        // R4 and R5: parked takers woken in parking order
        cfg_part = NCW'(3);
        fork do_deq(0); join_none
        repeat (6) @(negedge clk);
        chk(q_state == 2'd0, "R4 parked take keeps empty", q_state, 0);
        fork do_deq(1); join_none
        repeat (4) @(negedge clk);
        chk(exp_port.size() == 0, "R4 no response while parked", exp_port.size(), 0);
        expect_take(0, 16'hC001, 0, "R5 wake order");
        expect_take(1, 16'hC002, 0, "R5 wake order");
        do_enq(2, 16'hC001, 1'b0, "R5 add");
        do_enq(2, 16'hC002, 1'b0, "R5 add");
        wait fork;
        @(negedge clk);
        chk(q_state == 2'd0 && exp_port.size() == 0, "R5 all woken", q_state, 0);

        // R6 and R7: completion barrier and acknowledge
        expect_take(0, '0, 1, "R6 barrier");
        expect_take(1, '0, 1, "R6 barrier");
        expect_take(2, '0, 1, "R6 barrier");
        fork do_deq(0); do_deq(1); do_deq(2); join
        @(negedge clk);
        chk(q_state == 2'd3, "R6 completed state", q_state, 3);
        chk(exp_port.size() == 0, "R6 all notified", exp_port.size(), 0);
        fork do_enq(1, 16'hD001, 1'b0, "R7 add after reopen"); join_none
        quiet = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (enq_rsp != '0) quiet = 1'b0;
        end
        chk(quiet, "R7 add held during barrier", int'(!quiet), 0);
        @(posedge clk); #1 bar_ack = 4'b0011;
        @(posedge clk); #1 bar_ack = '0;
        @(negedge clk);
        chk(q_state == 2'd3, "R7 partial acknowledge", q_state, 3);
        @(posedge clk); #1 bar_ack = 4'b0100;
        @(posedge clk); #1 bar_ack = '0;
        @(negedge clk);
        chk(q_state == 2'd0, "R7 reopened empty", q_state, 0);
        wait fork;
        expect_take(0, 16'hD001, 0, "R7 service resumed");
        do_deq(0);

        // R8: round-robin among simultaneous adds
        cfg_part = NCW'(4);
        cfg_limit = CW'(8);
        do_enq(3, 16'hE003, 1'b0, "R8 add");
        fork
            do_enq(0, 16'hE100, 1'b0, "R8 add");
            do_enq(1, 16'hE101, 1'b0, "R8 add");
            do_enq(2, 16'hE102, 1'b0, "R8 add");
        join
        fork
            do_enq(0, 16'hF100, 1'b0, "R8 add");
            do_enq(3, 16'hF103, 1'b0, "R8 add");
        join
        expect_take(1, 16'hE003, 0, "R8 grant order");
        expect_take(1, 16'hE100, 0, "R8 grant order");
        expect_take(1, 16'hE101, 0, "R8 grant order");
        expect_take(1, 16'hE102, 0, "R8 grant order");
        expect_take(1, 16'hF103, 0, "R8 grant order");
        expect_take(1, 16'hF100, 0, "R8 grant order");
        repeat (6) do_deq(1);

        // R9: port outside the participant set is ignored
        cfg_part = NCW'(2);
        @(posedge clk); #1;
        enq_data[3*W +: W] = 16'h9999;
        enq_req[3] = 1'b1;
        quiet = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (enq_rsp[3]) quiet = 1'b0;
        end
        chk(quiet, "R9 outsider add unanswered", int'(!quiet), 0);
        chk(q_state == 2'd0, "R9 outsider stored nothing", q_state, 0);
        @(posedge clk); #1 enq_req[3] = 1'b0;

        repeat (3) @(negedge clk);
        chk(exp_port.size() == 0, "R2 scoreboard drained", exp_port.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule